// File: doc/BRIEF.md
# Register-Controlled PWM Generator

A single-channel pulse-width modulator set up through one 32-bit control word. The word holds four things:

- an enable bit;
- an idle-level bit;
- an 8-bit reload value, which divides the input clock down to a tick rate;
- an 8-bit duty value, which sets how many of the 256 ticks in each period are spent low.

Software writes the whole word through a synchronous write-enable/data port and can read it back at any time. To change one field, software reads the word, modifies it and writes it back.

While enabled, every period begins with its low phase. The output rises when the tick counter reaches the duty value. Reload and duty values written during a period are held back until that period ends, so no partial period appears on the output. While disabled, the counters stop at zero and the output sits at the idle level. A duty of zero also parks the output at the idle level. Clearing the enable bit leaves the reload and duty fields untouched, so setting it again restarts the same waveform from the start of a low phase.

Top module: `pwm_ctl_gen`

## Requirements
- R1: The synchronous active-high reset clears the control word to zero. After reset, `rd_data` is 0 and `pwm_out` is 0, including when the reset arrives while the block is running.
- R2: The control word reads back on `rd_data` with the following layout. All other bits read as 0.
  - Bit 31: enable.
  - Bit 30: idle level.
  - Bits 15:8: reload.
  - Bits 7:0: duty.
- R3: While the enable bit is 0, `pwm_out` equals the idle-level bit, whatever the duty and reload fields hold.
- R4: While enabled with a duty value D from 1 to 255, each period is 256 ticks long. The first D ticks are low and the remaining 256−D ticks are high. The low phase starts at the first tick after enabling.
- R5: One tick lasts N input clock cycles for a reload value N from 1 to 255. A reload value of 0 gives 256 cycles per tick.
- R6: While enabled with a duty value of 0, `pwm_out` stays at the idle-level bit and does not toggle.
- R7: Duty and reload values written while enabled take effect only at the next period boundary. The current period finishes with the values it started with.
- R8: Clearing the enable bit keeps the reload and duty fields. It also stops the counters and resets them, so setting the enable bit again restarts the same waveform with a low phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock, also the count source |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Current control word |
| pwm_out | output | 1 | PWM output |

## Verification
The hardest situation to reach from the ports is a field update that lands in the middle of a running period. The old values must finish that period before the new ones take over. The bench enables a known waveform and counts low and high cycles per sample. It writes a new duty value 100 cycles into the period, then checks two things: the remaining samples of that period follow the old duty, and the next full period follows the new one. A disable in the middle of a period is then followed by a read-modify-write re-enable. This shows that the fields survive and that the waveform restarts with its low phase.

// File: rtl/pwm_ctl_gen.sv
module pwm_ctl_gen #(
  parameter int FW = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        pwm_out
);
  localparam int EN_BIT  = 31;
  localparam int LVL_BIT = 30;
  localparam int RLD_LSB = FW;
  localparam int SP_LSB  = 2 * FW;

  logic          en_q, lvl_q, en_d, lvl_d;
  logic [FW-1:0] duty_q, rld_q, duty_d, rld_d;
  logic [FW-1:0] act_duty, act_rld, pre_q, cnt_q, div_m1;
  logic          tick, wrap, load;
  logic          unused_spare;

  assign unused_spare = ^wr_data[LVL_BIT-1:SP_LSB];

  always_comb begin
    en_d   = en_q;
    lvl_d  = lvl_q;
    duty_d = duty_q;
    rld_d  = rld_q;
    if (wr_en) begin
      en_d   = wr_data[EN_BIT];
      lvl_d  = wr_data[LVL_BIT];
      duty_d = wr_data[FW-1:0];
      rld_d  = wr_data[RLD_LSB +: FW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      lvl_q  <= 1'b0;
      duty_q <= '0;
      rld_q  <= '0;
    end else begin
      en_q   <= en_d;
      lvl_q  <= lvl_d;
      duty_q <= duty_d;
      rld_q  <= rld_d;
    end
  end

  always_comb begin
    rd_data                  = '0;
    rd_data[EN_BIT]          = en_q;
    rd_data[LVL_BIT]         = lvl_q;
    rd_data[FW-1:0]          = duty_q;
    rd_data[RLD_LSB +: FW]   = rld_q;
  end

  assign div_m1 = act_rld - {{(FW-1){1'b0}}, 1'b1};
  assign tick   = (pre_q == div_m1);
  assign wrap   = tick && (cnt_q == {FW{1'b1}});
  assign load   = !en_q || wrap;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_duty <= '0;
      act_rld  <= '0;
      pre_q    <= '0;
      cnt_q    <= '0;
    end else begin
      if (load) begin
        act_duty <= duty_d;
        act_rld  <= rld_d;
      end
      if (!en_q) begin
        pre_q <= '0;
        cnt_q <= '0;
      end else begin
        pre_q <= tick ? '0 : pre_q + 1'b1;
        if (tick) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign pwm_out = (en_q && act_duty != '0) ? (cnt_q >= act_duty) : lvl_q;

  AST_IDLE_OUT: assert property (@(posedge clk) disable iff (rst)
    !en_q |-> pwm_out == lvl_q); // R3

  AST_LOW_FIRST: assert property (@(posedge clk) disable iff (rst)
    (en_q && act_duty != '0 && cnt_q == '0) |-> !pwm_out); // R4

  AST_PRE_BOUND: assert property (@(posedge clk) disable iff (rst)
    en_q |-> pre_q <= div_m1); // R5

  AST_ACT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (en_q && $past(en_q) && !$past(wrap)) |-> ($stable(act_duty) && $stable(act_rld))); // R7

  AST_STOPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(!en_q) |-> (pre_q == '0 && cnt_q == '0)); // R8

endmodule

// File: tb/pwm_ctl_gen_tb.sv
module pwm_ctl_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;
  // reload, duty, expected low cycles, expected high cycles
  localparam int VEC [NV][4] = '{
    '{1, 1, 1, 255},
    '{1, 128, 128, 128},
    '{1, 255, 255, 1},
    '{2, 64, 128, 384},
    '{3, 200, 600, 168},
    '{4, 10, 40, 984}
  };

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic pwm_out;
  int checks = 0, failures = 0;
  int lo, hi, rise;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_ctl_gen dut_i (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
                     .rd_data(rd_data), .pwm_out(pwm_out));

  function automatic logic [31:0] mk(input bit en, input bit lvl, input int rld, input int duty);
    mk = {en, lvl, 14'b0, rld[7:0], duty[7:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    wr_en = 1'b1;
    wr_data = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic measure(input int n);
    lo = 0; hi = 0; rise = -1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out) begin
        hi++;
        if (rise < 0) rise = i;
      end else lo++;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(rd_data == 0, "R1 reset rd", rd_data, 0);
    chk(pwm_out == 0, "R1 reset out", pwm_out, 0);

    for (int v = 0; v < NV; v++) begin
      wr(mk(1, 0, VEC[v][0], VEC[v][1]));
      measure(256 * VEC[v][0]);
      chk(rd_data == mk(1, 0, VEC[v][0], VEC[v][1]), "R2 readback", rd_data, mk(1, 0, VEC[v][0], VEC[v][1]));
      chk(lo == VEC[v][2], "R4 low cycles", lo, VEC[v][2]);
      chk(hi == VEC[v][3], "R5 high cycles", hi, VEC[v][3]);
      chk(rise == VEC[v][2], "R4 low first", rise, VEC[v][2]);
      wr(mk(0, 0, VEC[v][0], VEC[v][1]));
    end

    wr(mk(1, 0, 0, 1));
    measure(300);
    chk(lo == 256, "R5 reload zero", lo, 256);
    wr(mk(0, 0, 0, 1));

    wr(mk(0, 1, 3, 77) | 32'h0012_0000);
    chk(rd_data == mk(0, 1, 3, 77), "R2 spare bits zero", rd_data, mk(0, 1, 3, 77));
    measure(20);
    chk(hi == 20, "R3 idle high", hi, 20);
    wr(mk(0, 0, 3, 77));
    measure(20);
    chk(lo == 20, "R3 idle low", lo, 20);

    wr(mk(1, 1, 1, 0));
    measure(300);
    chk(hi == 300, "R6 duty zero level 1", hi, 300);
    wr(mk(0, 0, 1, 0));
    wr(mk(1, 0, 1, 0));
    measure(300);
    chk(lo == 300, "R6 duty zero level 0", lo, 300);
    wr(mk(0, 0, 1, 0));

    wr(mk(1, 0, 1, 50));
    measure(100);
    chk(lo == 50, "R7 before update", lo, 50);
    wr(mk(1, 0, 1, 200));
    measure(156);
    chk(lo == 0, "R7 rest of old period", lo, 0);
    measure(256);
    chk(lo == 200, "R7 new period", lo, 200);

    measure(70);
    wr(mk(0, 1, 1, 200));
    @(negedge clk);
    chk(pwm_out == 1, "R3 disabled mid period", pwm_out, 1);
    chk(rd_data == mk(0, 1, 1, 200), "R8 fields kept", rd_data, mk(0, 1, 1, 200));
    wr(rd_data | 32'h8000_0000);
    measure(256);
    chk(rise == 200, "R8 restart low first", rise, 200);
    chk(lo == 200, "R8 same waveform", lo, 200);

    measure(30);
    rst = 1'b1;
    @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(rd_data == 0, "R1 mid-run reset rd", rd_data, 0);
    chk(pwm_out == 0, "R1 mid-run reset out", pwm_out, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule